// File: doc/BRIEF.md
# Multi-Source Timer Capture Unit

This block gives a free-running 16-bit timer four independent capture channels. Each channel watches one trigger source chosen by software. The source can be an edge on the channel's own input pin, an overflow pulse from either of two neighbouring timers, or an event from the analog comparator pair. When the trigger fires, the channel stores the timer count as it stands in that cycle. It also stores the count direction and raises a sticky event flag. The timer, the comparators and interrupt arbitration sit outside the block and reach it only as input signals.

Each pin passes through a two-flop synchronizer and then a four-state qualification machine, which accepts a new level only after two matching samples in a row. The machine has these states. `FL_LOW` is a settled low level. `FL_RISING` means one high sample has been seen. `FL_HIGH` is a settled high level. `FL_FALLING` means one low sample has been seen. It moves along these transitions:

- `FL_LOW`→`FL_RISING` on a high sample.
- `FL_RISING`→`FL_HIGH` on a second high sample, which emits a rise event.
- `FL_RISING`→`FL_LOW` on a low sample, which discards a glitch.
- `FL_HIGH`→`FL_FALLING` on a low sample.
- `FL_FALLING`→`FL_LOW` on a second low sample, which emits a fall event.
- `FL_FALLING`→`FL_HIGH` on a high sample, which discards a glitch.

Every other state holds. A per-channel block input suppresses pin triggers only. There is no overrun protection: a later capture overwrites the stored count.

Top module: `capture_unit`

## Requirements
- R1: After reset all capture counts are 0, all direction bits are 0, all flags are 0, and every channel's configuration is 0 (pin source, edge detection off).
- R2: A pin level change is accepted only after two consecutive synchronized samples agree. A change driven before a rising clock edge produces its capture at the fourth rising edge, and not earlier. A level that lasts a single cycle produces no capture.
- R3: In pin mode the 2-bit edge field selects the trigger: 00 none, 01 falling edge, 10 rising edge, 11 both edges.
- R4: The 2-bit source field selects the trigger: 00 pin, 01 timer-A overflow, 10 timer-B overflow, 11 comparator event. Sources that are not selected have no effect.
- R5: On a trigger, `tmr_count` sampled in the trigger cycle appears on the channel's slice of `cap_data` after the next rising edge. Channel i occupies bits [16i+15:16i].
- R6: On a trigger, the direction bit takes `tmr_down` when `tmr_dual` is 1 (0 up, 1 down). It takes 0 when `tmr_dual` is 0.
- R7: A channel's capture count changes only on a trigger. A new trigger overwrites an unread count.
- R8: A capture sets the channel's flag, and the flag stays set until a 1 is written on that channel's `flag_clr` bit. If a clear and a capture occur in the same cycle, the flag ends up set.
- R9: While `pin_block[i]` is 1, pin edges cannot trigger channel i. Overflow and comparator triggers still work.
- R10: A configuration write with `cfg_we` uses `cfg_wdata[3:2]` as the source field and `cfg_wdata[1:0]` as the edge field for channel `cfg_ch`. A trigger in the write cycle is judged by the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_count | input | 16 | Current timer count |
| tmr_down | input | 1 | Timer counting down (1) or up (0) |
| tmr_dual | input | 1 | Timer in dual-slope mode |
| ovf_a | input | 1 | Timer-A overflow pulse |
| ovf_b | input | 1 | Timer-B overflow pulse |
| cmp_evt | input | 1 | Comparator event pulse |
| cap_pin | input | 4 | Asynchronous capture pins, one per channel |
| pin_block | input | 4 | Per-channel block of pin triggers |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_wdata | input | 4 | {source[1:0], edge[1:0]} |
| flag_clr | input | 4 | Write-1-to-clear for event flags |
| cap_data | output | 64 | Captured counts, 16 bits per channel |
| cap_dir | output | 4 | Captured direction bits |
| cap_flag | output | 4 | Sticky event flags |

## Verification
A qualification machine stuck in an intermediate state shows up as a missing or spurious flag on the pin channel, within four cycles of a pin change. Because the check samples exactly one cycle before and at the expected edge, a filter that is one stage short or long is caught. A wrong source decode or a stale configuration register shows up as a flag pattern across the four channels that differs from the selected sources, one cycle after the source pulse. A capture register that loses its hold shows up as a count that drifts between triggers.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        SRC_PIN  = 2'b00,
        SRC_OVFA = 2'b01,
        SRC_OVFB = 2'b10,
        SRC_CMP  = 2'b11
    } trig_src_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef enum logic [1:0] {
        FL_LOW     = 2'b00,
        FL_RISING  = 2'b01,
        FL_HIGH    = 2'b10,
        FL_FALLING = 2'b11
    } filt_state_e;

endpackage

// File: rtl/cap_pin_filter.sv
module cap_pin_filter
    import cap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise_evt,
    output logic fall_evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   smp;
    filt_state_e            state_q;
    filt_state_e            state_d;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_async;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
            end
        end
    endgenerate

    assign smp = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_LOW;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        rise_evt = 1'b0;
        fall_evt = 1'b0;
        unique case (state_q)
            FL_LOW: begin
                if (smp) state_d = FL_RISING;
            end
            FL_RISING: begin
                if (smp) begin
                    state_d  = FL_HIGH;
                    rise_evt = 1'b1;
                end else begin
                    state_d  = FL_LOW;
                end
            end
            FL_HIGH: begin
                if (!smp) state_d = FL_FALLING;
            end
            FL_FALLING: begin
                if (!smp) begin
                    state_d  = FL_LOW;
                    fall_evt = 1'b1;
                end else begin
                    state_d  = FL_HIGH;
                end
            end
        endcase
    end

endmodule

// File: rtl/cap_trig_mux.sv
module cap_trig_mux
    import cap_pkg::*;
(
    input  trig_src_e  src,
    input  edge_mode_e edge_mode,
    input  logic       pin_rise,
    input  logic       pin_fall,
    input  logic       pin_block,
    input  logic       ovf_a,
    input  logic       ovf_b,
    input  logic       cmp_evt,
    output logic       hit
);

    logic pin_hit;

    always_comb begin
        pin_hit = 1'b0;
        unique case (edge_mode)
            EDGE_OFF:  pin_hit = 1'b0;
            EDGE_FALL: pin_hit = pin_fall;
            EDGE_RISE: pin_hit = pin_rise;
            EDGE_BOTH: pin_hit = pin_rise | pin_fall;
        endcase
    end

    always_comb begin
        hit = 1'b0;
        unique case (src)
            SRC_PIN:  hit = pin_hit & ~pin_block;
            SRC_OVFA: hit = ovf_a;
            SRC_OVFB: hit = ovf_b;
            SRC_CMP:  hit = cmp_evt;
        endcase
    end

endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_wdata,
    input  logic             flag_clr,
    input  logic             cap_pin,
    input  logic             pin_block,
    input  logic             ovf_a,
    input  logic             ovf_b,
    input  logic             cmp_evt,
    input  logic [CNT_W-1:0] tmr_count,
    input  logic             tmr_down,
    input  logic             tmr_dual,
    output logic [CNT_W-1:0] cap_data,
    output logic             cap_dir,
    output logic             cap_flag,
    output logic             hit
);

    trig_src_e  src_q;
    edge_mode_e edge_q;
    logic       pin_rise;
    logic       pin_fall;

    cap_pin_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (cap_pin),
        .rise_evt  (pin_rise),
        .fall_evt  (pin_fall)
    );

    cap_trig_mux u_mux (
        .src       (src_q),
        .edge_mode (edge_q),
        .pin_rise  (pin_rise),
        .pin_fall  (pin_fall),
        .pin_block (pin_block),
        .ovf_a     (ovf_a),
        .ovf_b     (ovf_b),
        .cmp_evt   (cmp_evt),
        .hit       (hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= SRC_PIN;
            edge_q <= EDGE_OFF;
        end else if (cfg_we) begin
            src_q  <= trig_src_e'(cfg_wdata[3:2]);
            edge_q <= edge_mode_e'(cfg_wdata[1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_data <= '0;
            cap_dir  <= 1'b0;
        end else if (hit) begin
            cap_data <= tmr_count;
            cap_dir  <= tmr_dual & tmr_down;
        end
    end

    // capture outranks a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cap_flag <= 1'b0;
        else if (hit)      cap_flag <= 1'b1;
        else if (flag_clr) cap_flag <= 1'b0;
    end

endmodule

// File: rtl/capture_unit.sv
module capture_unit
    import cap_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        tmr_count,
    input  logic                    tmr_down,
    input  logic                    tmr_dual,
    input  logic                    ovf_a,
    input  logic                    ovf_b,
    input  logic                    cmp_evt,
    input  logic [N_CH-1:0]         cap_pin,
    input  logic [N_CH-1:0]         pin_block,
    input  logic                    cfg_we,
    input  logic [$clog2(N_CH)-1:0] cfg_ch,
    input  logic [3:0]              cfg_wdata,
    input  logic [N_CH-1:0]         flag_clr,
    output logic [N_CH*CNT_W-1:0]   cap_data,
    output logic [N_CH-1:0]         cap_dir,
    output logic [N_CH-1:0]         cap_flag
);

    localparam int CH_W = $clog2(N_CH);

    logic [N_CH-1:0] hit;

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            logic ch_we;
            assign ch_we = cfg_we && (cfg_ch == CH_W'(i));

            cap_channel #(
                .CNT_W       (CNT_W),
                .SYNC_STAGES (SYNC_STAGES)
            ) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .cfg_we    (ch_we),
                .cfg_wdata (cfg_wdata),
                .flag_clr  (flag_clr[i]),
                .cap_pin   (cap_pin[i]),
                .pin_block (pin_block[i]),
                .ovf_a     (ovf_a),
                .ovf_b     (ovf_b),
                .cmp_evt   (cmp_evt),
                .tmr_count (tmr_count),
                .tmr_down  (tmr_down),
                .tmr_dual  (tmr_dual),
                .cap_data  (cap_data[i*CNT_W +: CNT_W]),
                .cap_dir   (cap_dir[i]),
                .cap_flag  (cap_flag[i]),
                .hit       (hit[i])
            );
        end
    endgenerate

endmodule

// File: rtl/capture_unit_chk.sv
module capture_unit_chk #(
    parameter int N_CH  = 4,
    parameter int CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [CNT_W-1:0]      tmr_count,
    input logic                  tmr_down,
    input logic                  tmr_dual,
    input logic [N_CH-1:0]       flag_clr,
    input logic [N_CH-1:0]       hit,
    input logic [N_CH*CNT_W-1:0] cap_data,
    input logic [N_CH-1:0]       cap_dir,
    input logic [N_CH-1:0]       cap_flag
);

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_a
            a_r5_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
                hit[i] |=> cap_data[i*CNT_W +: CNT_W] == $past(tmr_count));

            a_r6_dir_follows_dual: assert property (@(posedge clk) disable iff (!rst_n)
                hit[i] && tmr_dual |=> cap_dir[i] == $past(tmr_down));

            a_r6_dir_up_single: assert property (@(posedge clk) disable iff (!rst_n)
                hit[i] && !tmr_dual |=> !cap_dir[i]);

            a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
                !hit[i] |=> $stable(cap_data[i*CNT_W +: CNT_W]));

            a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
                hit[i] |=> cap_flag[i]);

            a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                cap_flag[i] && !flag_clr[i] |=> cap_flag[i]);

            a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
                !hit[i] && flag_clr[i] |=> !cap_flag[i]);
        end
    endgenerate

endmodule

bind capture_unit capture_unit_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_count (tmr_count),
    .tmr_down  (tmr_down),
    .tmr_dual  (tmr_dual),
    .flag_clr  (flag_clr),
    .hit       (hit),
    .cap_data  (cap_data),
    .cap_dir   (cap_dir),
    .cap_flag  (cap_flag)
);

// File: tb/capture_unit_test.sv
module capture_unit_test;

    localparam int N_CH  = 4;
    localparam int CNT_W = 16;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [CNT_W-1:0]      tmr_count = '0;
    logic                  tmr_down = 1'b0;
    logic                  tmr_dual = 1'b0;
    logic                  ovf_a = 1'b0;
    logic                  ovf_b = 1'b0;
    logic                  cmp_evt = 1'b0;
    logic [N_CH-1:0]       cap_pin = '0;
    logic [N_CH-1:0]       pin_block = '0;
    logic                  cfg_we = 1'b0;
    logic [1:0]            cfg_ch = '0;
    logic [3:0]            cfg_wdata = '0;
    logic [N_CH-1:0]       flag_clr = '0;
    logic [N_CH*CNT_W-1:0] cap_data;
    logic [N_CH-1:0]       cap_dir;
    logic [N_CH-1:0]       cap_flag;

    int n_vec = 0;
    int n_bad = 0;

    capture_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmr_count (tmr_count),
        .tmr_down  (tmr_down),
        .tmr_dual  (tmr_dual),
        .ovf_a     (ovf_a),
        .ovf_b     (ovf_b),
        .cmp_evt   (cmp_evt),
        .cap_pin   (cap_pin),
        .pin_block (pin_block),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_wdata (cfg_wdata),
        .flag_clr  (flag_clr),
        .cap_data  (cap_data),
        .cap_dir   (cap_dir),
        .cap_flag  (cap_flag)
    );

    always #5 clk = ~clk;

    // sels = {ch3,ch2,ch1,ch0} source codes; src = {ovf_a, ovf_b, cmp_evt}
    typedef struct packed {
        logic [7:0]  sels;
        logic [2:0]  src;
        logic [15:0] cnt;
        logic        down;
        logic        dual;
        logic [3:0]  mask;
        logic [3:0]  dir;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'b11_10_01_00, 3'b100, 16'h1234, 1'b1, 1'b1, 4'b0010, 4'b0010},
        '{8'b11_10_01_00, 3'b010, 16'hBEEF, 1'b1, 1'b0, 4'b0100, 4'b0000},
        '{8'b11_10_01_00, 3'b001, 16'h0001, 1'b1, 1'b1, 4'b1000, 4'b1000},
        '{8'b11_10_01_00, 3'b111, 16'hFFFF, 1'b0, 1'b1, 4'b1110, 4'b0000},
        '{8'b01_01_01_01, 3'b100, 16'h8000, 1'b1, 1'b1, 4'b1111, 4'b1111},
        '{8'b01_01_01_01, 3'b011, 16'h7777, 1'b1, 1'b1, 4'b0000, 4'b0000},
        '{8'b00_00_00_00, 3'b111, 16'h4242, 1'b0, 1'b0, 4'b0000, 4'b0000},
        '{8'b10_11_01_10, 3'b011, 16'h5A5A, 1'b0, 1'b0, 4'b1101, 4'b0000}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] slice(input int ch);
        return cap_data[ch*CNT_W +: CNT_W];
    endfunction

    // all tasks start and end at a falling edge
    task automatic cfg(input int ch, input logic [3:0] v);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clr(input logic [3:0] m);
        flag_clr = m;
        @(negedge clk);
        flag_clr = '0;
    endtask

    task automatic pulse(input logic [2:0] s, input logic [15:0] c, input logic d, input logic du);
        {ovf_a, ovf_b, cmp_evt} = s; tmr_count = c; tmr_down = d; tmr_dual = du;
        @(negedge clk);
        {ovf_a, ovf_b, cmp_evt} = 3'b000;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check(cap_data == '0 && cap_dir == '0 && cap_flag == '0, "R1 reset",
              {cap_flag, cap_dir, 56'(cap_data)}, 64'h0);

        // table walk: R4 source decode, R5 value, R6 direction
        for (int v = 0; v < 8; v++) begin
            bit ok;
            for (int c = 0; c < N_CH; c++) cfg(c, {VECS[v].sels[2*c +: 2], 2'b00});
            clr(4'hF);
            pulse(VECS[v].src, VECS[v].cnt, VECS[v].down, VECS[v].dual);
            ok = (cap_flag == VECS[v].mask) && ((cap_dir & VECS[v].mask) == VECS[v].dir);
            for (int c = 0; c < N_CH; c++)
                if (VECS[v].mask[c] && slice(c) != VECS[v].cnt) ok = 1'b0;
            check(ok, "R4/R5/R6 table", {cap_flag, cap_dir & VECS[v].mask, 16'h0, slice(0)},
                  {VECS[v].mask, VECS[v].dir, 16'h0, VECS[v].cnt});
        end

        // R2 / R3 rising edge timing on ch0
        tmr_count = 16'hA5A5; tmr_dual = 1'b0;
        cfg(0, 4'b00_10);
        clr(4'hF);
        cap_pin[0] = 1'b1;
        idle(3);
        check(cap_flag[0] == 1'b0, "R2 not before fourth edge", 64'(cap_flag[0]), 64'h0);
        idle(1);
        check(cap_flag[0] == 1'b1 && slice(0) == 16'hA5A5, "R2 R3 rise capture",
              {cap_flag, slice(0)}, {4'b0001, 16'hA5A5});

        // R2 single-cycle glitch low then back high: no fall event
        cfg(0, 4'b00_01);
        clr(4'hF);
        cap_pin[0] = 1'b0;
        idle(1);
        cap_pin[0] = 1'b1;
        idle(6);
        check(cap_flag[0] == 1'b0, "R2 glitch ignored", 64'(cap_flag[0]), 64'h0);

        // R3 falling mode: fall captures
        cap_pin[0] = 1'b0;
        idle(4);
        check(cap_flag[0] == 1'b1, "R3 falling edge", 64'(cap_flag[0]), 64'h1);

        // R3 falling mode ignores rise
        clr(4'hF);
        cap_pin[0] = 1'b1;
        idle(6);
        check(cap_flag[0] == 1'b0, "R3 rise ignored in fall mode", 64'(cap_flag[0]), 64'h0);

        // R3 both edges
        cfg(0, 4'b00_11);
        clr(4'hF);
        tmr_count = 16'h0F0F;
        cap_pin[0] = 1'b0;
        idle(4);
        check(cap_flag[0] == 1'b1 && slice(0) == 16'h0F0F, "R3 both: fall",
              {cap_flag, slice(0)}, {4'b0001, 16'h0F0F});
        clr(4'hF);
        tmr_count = 16'hF0F0;
        cap_pin[0] = 1'b1;
        idle(4);
        check(cap_flag[0] == 1'b1 && slice(0) == 16'hF0F0, "R3 both: rise",
              {cap_flag, slice(0)}, {4'b0001, 16'hF0F0});

        // R3 edge off
        cfg(0, 4'b00_00);
        clr(4'hF);
        tmr_count = 16'h1111;
        cap_pin[0] = 1'b0;
        idle(6);
        check(cap_flag[0] == 1'b0 && slice(0) == 16'hF0F0, "R3 edge off",
              {cap_flag, slice(0)}, {4'b0000, 16'hF0F0});

        // R9 pin block
        cfg(0, 4'b00_11);
        pin_block[0] = 1'b1;
        clr(4'hF);
        cap_pin[0] = 1'b1;
        idle(6);
        check(cap_flag[0] == 1'b0 && slice(0) == 16'hF0F0, "R9 pin blocked",
              {cap_flag, slice(0)}, {4'b0000, 16'hF0F0});
        cfg(0, 4'b01_00);
        pulse(3'b100, 16'h3C3C, 1'b0, 1'b0);
        check(cap_flag[0] == 1'b1 && slice(0) == 16'h3C3C, "R9 overflow passes block",
              {cap_flag, slice(0)}, {4'b0001, 16'h3C3C});
        pin_block[0] = 1'b0;

        // R7 overwrite without read (ch1 source ovf_a from last vector)
        clr(4'hF);
        pulse(3'b100, 16'h1111, 1'b0, 1'b0);
        idle(2);
        check(slice(1) == 16'h1111, "R7 hold between triggers", 64'(slice(1)), 64'h1111);
        pulse(3'b100, 16'h2222, 1'b0, 1'b0);
        check(slice(1) == 16'h2222 && cap_flag[1], "R7 overwrite",
              {cap_flag, slice(1)}, {4'b0011, 16'h2222});

        // R8 sticky, clear vs capture, clear alone
        idle(3);
        check(cap_flag[1] == 1'b1, "R8 sticky", 64'(cap_flag[1]), 64'h1);
        flag_clr = 4'b0010;
        pulse(3'b100, 16'h3333, 1'b0, 1'b0);
        flag_clr = '0;
        check(cap_flag[1] == 1'b1, "R8 capture beats clear", 64'(cap_flag[1]), 64'h1);
        clr(4'b0010);
        check(cap_flag[1] == 1'b0, "R8 clear", 64'(cap_flag[1]), 64'h0);

        // R10 write in trigger cycle uses old config (ch2 was comparator)
        clr(4'hF);
        cfg_we = 1'b1; cfg_ch = 2'd2; cfg_wdata = 4'b01_00;
        pulse(3'b001, 16'h6666, 1'b0, 1'b0);
        cfg_we = 1'b0;
        check(cap_flag[2] == 1'b1 && slice(2) == 16'h6666, "R10 old config in write cycle",
              {cap_flag, slice(2)}, {4'b0100, 16'h6666});
        clr(4'hF);
        pulse(3'b001, 16'h7777, 1'b0, 1'b0);
        check(cap_flag[2] == 1'b0, "R10 new config drops comparator", 64'(cap_flag[2]), 64'h0);
        pulse(3'b100, 16'h8888, 1'b0, 1'b0);
        check(cap_flag[2] == 1'b1 && slice(2) == 16'h8888, "R10 new config ovf_a",
              {cap_flag[2], slice(2)}, {1'b1, 16'h8888});

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule